// File: doc/BRIEF.md
# Multiprocessor Interrupt Pending Distributor

This block keeps the pending and active state of a small set of interrupt lines that several processors share. A processor pulses an acknowledge strobe to take an interrupt. One cycle later the block returns the number of the lowest pending source that the processor may take, or a reserved spurious number if there is none. When the processor has finished its handler, it pulses end-of-interrupt together with that number.

Each source has a 4-bit configuration. It selects edge or level capture and the delivery mode. In one-of-N mode the first processor to acknowledge claims the occurrence. In all-N mode every processor holds its own pending copy. The configuration also marks a source as secure and enables it. Configuration writes and reads carry a secure tag. A non-secure access cannot see or change a secure source.

Top module: `irqd_top`

## Requirements
- R1: An edge source (config bit 0 = 1) becomes pending one cycle after a rising edge on its line. After it is acknowledged and ended, it is not signalled again while the line stays high. It needs a fresh rising edge.
- R2: A level source (config bit 0 = 0) is pending one cycle after its line goes high. It stops being pending one cycle after the line goes low, so an acknowledge at that point returns the spurious ID.
- R3: When several sources may be taken by a processor, an acknowledge returns the lowest-numbered one.
- R4: In one-of-N mode (config bit 1 = 0), the first processor to acknowledge claims the occurrence. A later acknowledge from any other processor returns the spurious ID.
- R5: When two processors acknowledge the same one-of-N source in one cycle, the lower processor index gets it and the other gets the spurious ID.
- R6: In all-N mode (config bit 1 = 1), each processor has its own pending state. Acknowledging on one processor leaves the source pending on the others, including when the acknowledges are simultaneous.
- R7: An acknowledge with nothing to take returns 1023. The returned ID is held on that processor's output until its next acknowledge. After reset every ID output reads 1023 and every processor request output is low.
- R8: An acknowledged source is active for that processor. It is not returned to that processor again until end-of-interrupt arrives carrying the same ID. An end-of-interrupt carrying a different ID leaves it active.
- R9: A level source whose line is still high when end-of-interrupt arrives is pending again on the following cycle.
- R10: Config bit 2 marks a source secure. A non-secure write to a secure source is ignored, and a non-secure read of it returns 0. A non-secure write to a non-secure source stores bit 2 as 0. Secure accesses read and write every bit.
- R11: A source whose enable (config bit 3) is 0 drives no processor request. An acknowledge then returns 1023 even if the source was pending before it was disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_line | input | NUM_SRC | Interrupt lines, one per source |
| ack_stb | input | NUM_CPU | Acknowledge strobe per processor |
| ack_id | output | NUM_CPU*10 | Returned ID per processor, valid the cycle after the strobe |
| eoi_stb | input | NUM_CPU | End-of-interrupt strobe per processor |
| eoi_id | input | NUM_CPU*10 | ID being ended, per processor |
| cpu_irq | output | NUM_CPU | A source can be taken by this processor |
| cfg_we | input | 1 | Configuration write |
| cfg_sec | input | 1 | Access is tagged secure (applies to reads and writes) |
| cfg_idx | input | SRC_W | Source addressed by the configuration port |
| cfg_wdata | input | 4 | Configuration value: bit0 edge, bit1 all-N, bit2 secure, bit3 enable |
| cfg_rdata | output | 4 | Configuration read value for cfg_idx, filtered by cfg_sec |

## Verification
A table of line patterns is applied to level sources with processor 0 acknowledging. The table includes an empty pattern, single lines at both ends of the range, and mixed groups, which separates lowest-number selection from highest-number or first-set selection. Directed sequences then hold lines high across end-of-interrupt and pulse them. These runs separate edge capture from level capture and show re-pending after end-of-interrupt. Paired and simultaneous acknowledges on one-of-N and all-N sources show claiming and the tie-break by processor index. Secure and non-secure reads after blocked writes show that the configuration is left untouched.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
    localparam int ID_W = 10;
    localparam logic [ID_W-1:0] SPURIOUS_ID = '1;

    // bit 3 enable, bit 2 secure, bit 1 all-N delivery, bit 0 edge capture
    typedef struct packed {
        logic enable;
        logic secure;
        logic all_n;
        logic edge_trig;
    } src_cfg_t;
endpackage

// File: rtl/irqd_cfg_regs.sv
module irqd_cfg_regs
    import irqd_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int SRC_W   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    acc_sec,
    input  logic [SRC_W-1:0]        idx,
    input  src_cfg_t                wdata,
    output src_cfg_t                rdata,
    output src_cfg_t [NUM_SRC-1:0]  cfg_o
);
    src_cfg_t [NUM_SRC-1:0] cfg_d, cfg_q;
    logic                   idx_ok;

    assign idx_ok = int'(idx) < NUM_SRC;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && idx_ok) begin
            if (acc_sec) begin
                cfg_d[idx] = wdata;
            end else if (!cfg_q[idx].secure) begin
                cfg_d[idx]        = wdata;
                cfg_d[idx].secure = 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (idx_ok && (acc_sec || !cfg_q[idx].secure)) begin
            rdata = cfg_q[idx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/irqd_pick.sv
module irqd_pick #(
    parameter int NUM_SRC = 8,
    parameter int SRC_W   = 3
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               hit,
    output logic [SRC_W-1:0]   idx
);
    always_comb begin
        hit = |req;
        idx = '0;
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (req[s]) idx = SRC_W'(s);
        end
    end
endmodule

// File: rtl/irqd_top.sv
module irqd_top
    import irqd_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int NUM_CPU = 2,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SRC-1:0]      irq_line,
    input  logic [NUM_CPU-1:0]      ack_stb,
    output logic [NUM_CPU*ID_W-1:0] ack_id,
    input  logic [NUM_CPU-1:0]      eoi_stb,
    input  logic [NUM_CPU*ID_W-1:0] eoi_id,
    output logic [NUM_CPU-1:0]      cpu_irq,
    input  logic                    cfg_we,
    input  logic                    cfg_sec,
    input  logic [SRC_W-1:0]        cfg_idx,
    input  logic [3:0]              cfg_wdata,
    output logic [3:0]              cfg_rdata
);
    typedef struct packed {
        logic [NUM_SRC-1:0]                line;
        logic [NUM_CPU-1:0][NUM_SRC-1:0]   pend;
        logic [NUM_CPU-1:0][NUM_SRC-1:0]   act;
        logic [NUM_CPU-1:0][ID_W-1:0]      ack;
    } state_t;

    localparam state_t RST_ST = '{
        line: '0, pend: '0, act: '0, ack: {NUM_CPU{SPURIOUS_ID}}
    };

    state_t st_d, st_q;

    src_cfg_t [NUM_SRC-1:0]          cfg_arr;
    src_cfg_t                        rd_cfg;
    logic [NUM_SRC-1:0]              src_en, src_edge, src_alln;
    logic [NUM_SRC-1:0]              rise, claimed, any_act;
    logic [NUM_CPU-1:0][NUM_SRC-1:0] act_now, elig;
    logic [NUM_CPU-1:0]              pick_hit;
    logic [NUM_CPU-1:0][SRC_W-1:0]   pick_idx;
    logic [NUM_CPU-1:0][ID_W-1:0]    eoi_vec;

    irqd_cfg_regs #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .acc_sec(cfg_sec),
        .idx    (cfg_idx),
        .wdata  (src_cfg_t'(cfg_wdata)),
        .rdata  (rd_cfg),
        .cfg_o  (cfg_arr)
    );
    assign cfg_rdata = rd_cfg;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign src_en[s]   = cfg_arr[s].enable;
        assign src_edge[s] = cfg_arr[s].edge_trig;
        assign src_alln[s] = cfg_arr[s].all_n;
    end

    assign act_now = st_q.act;
    assign rise    = irq_line & ~st_q.line;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        assign elig[c]    = st_q.pend[c] & ~act_now[c] & src_en;
        assign cpu_irq[c] = |elig[c];
        assign eoi_vec[c] = eoi_id[c*ID_W +: ID_W];
        assign ack_id[c*ID_W +: ID_W] = st_q.ack[c];

        irqd_pick #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_pick (
            .req(elig[c]),
            .hit(pick_hit[c]),
            .idx(pick_idx[c])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.line = irq_line;
        claimed   = '0;
        any_act   = '0;

        // acknowledges, lower processor index first
        for (int c = 0; c < NUM_CPU; c++) begin
            if (ack_stb[c]) begin
                st_d.ack[c] = SPURIOUS_ID;
                if (pick_hit[c] && !claimed[pick_idx[c]]) begin
                    st_d.ack[c]              = ID_W'(pick_idx[c]);
                    st_d.pend[c][pick_idx[c]] = 1'b0;
                    st_d.act[c][pick_idx[c]]  = 1'b1;
                    if (!src_alln[pick_idx[c]]) begin
                        claimed[pick_idx[c]] = 1'b1;
                        for (int k = 0; k < NUM_CPU; k++) begin
                            st_d.pend[k][pick_idx[c]] = 1'b0;
                        end
                    end
                end
            end
        end

        // end of interrupt
        for (int c = 0; c < NUM_CPU; c++) begin
            if (eoi_stb[c] && (eoi_vec[c] < ID_W'(NUM_SRC))) begin
                st_d.act[c][eoi_vec[c][SRC_W-1:0]] = 1'b0;
            end
        end

        // line capture
        for (int s = 0; s < NUM_SRC; s++) begin
            for (int c = 0; c < NUM_CPU; c++) begin
                any_act[s] = any_act[s] | st_d.act[c][s];
            end
            for (int c = 0; c < NUM_CPU; c++) begin
                if (src_edge[s]) begin
                    st_d.pend[c][s] = st_d.pend[c][s] | rise[s];
                end else begin
                    st_d.pend[c][s] = irq_line[s] &
                        ~(src_alln[s] ? st_d.act[c][s] : any_act[s]);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irqd_chk.sv
module irqd_chk
    import irqd_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int NUM_CPU = 2,
    parameter int SRC_W   = 3
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NUM_CPU-1:0]              ack_stb,
    input logic [NUM_CPU*ID_W-1:0]         ack_id,
    input logic [NUM_CPU-1:0]              cpu_irq,
    input logic [NUM_CPU-1:0][NUM_SRC-1:0] act,
    input logic                            cfg_we,
    input logic                            cfg_sec,
    input logic [SRC_W-1:0]                cfg_idx,
    input src_cfg_t [NUM_SRC-1:0]          cfg_arr
);
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
        assert_id_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_id[c*ID_W +: ID_W] < ID_W'(NUM_SRC)) ||
            (ack_id[c*ID_W +: ID_W] == SPURIOUS_ID));

        assert_idle_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_stb[c] && !cpu_irq[c]) |=> (ack_id[c*ID_W +: ID_W] == SPURIOUS_ID));

        assert_id_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !ack_stb[c] |=> $stable(ack_id[c*ID_W +: ID_W]));

        for (genvar s = 0; s < NUM_SRC; s++) begin : g_s
            assert_no_reissue_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_stb[c] && act[c][s]) |=> (ack_id[c*ID_W +: ID_W] != ID_W'(s)));
        end
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_sec
        assert_secure_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && !cfg_sec && cfg_idx == SRC_W'(s) && cfg_arr[s].secure)
            |=> $stable(cfg_arr[s]));
    end
endmodule

bind irqd_top irqd_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .SRC_W(SRC_W)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ack_stb(ack_stb),
    .ack_id (ack_id),
    .cpu_irq(cpu_irq),
    .act    (act_now),
    .cfg_we (cfg_we),
    .cfg_sec(cfg_sec),
    .cfg_idx(cfg_idx),
    .cfg_arr(cfg_arr)
);

// File: tb/test_irqd_top.sv
module test_irqd_top;
    localparam int NS = 8;
    localparam int NC = 2;
    localparam int SP = 1023;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_line = '0;
    logic [NC-1:0] ack_stb = '0;
    logic [NC*10-1:0] ack_id;
    logic [NC-1:0] eoi_stb = '0;
    logic [NC*10-1:0] eoi_id = '0;
    logic [NC-1:0] cpu_irq;
    logic          cfg_we = 1'b0;
    logic          cfg_sec = 1'b0;
    logic [2:0]    cfg_idx = '0;
    logic [3:0]    cfg_wdata = '0;
    logic [3:0]    cfg_rdata;

    int total = 0;
    int bad = 0;
    bit done = 0;

    irqd_top #(.NUM_SRC(NS), .NUM_CPU(NC)) i_irqd_top (.*);

    always #5 clk = ~clk;

    // {line pattern, expected ID for processor 0}
    localparam logic [17:0] VEC [6] = '{
        {8'h00, 10'd1023}, {8'h01, 10'd0}, {8'h80, 10'd7},
        {8'h60, 10'd5},    {8'hFE, 10'd1}, {8'hA8, 10'd3}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int id_of(input int c);
        return int'(ack_id[c*10 +: 10]);
    endfunction

    task automatic ack(input logic [NC-1:0] m);
        @(negedge clk) ack_stb = m;
        @(negedge clk) ack_stb = '0;
    endtask

    task automatic eoi(input int c, input int id);
        @(negedge clk);
        eoi_stb[c] = 1'b1;
        eoi_id[c*10 +: 10] = 10'(id);
        @(negedge clk) eoi_stb = '0;
    endtask

    task automatic cfg_write(input int idx, input logic [3:0] v, input logic sec);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sec = sec; cfg_idx = 3'(idx); cfg_wdata = v;
        @(negedge clk) cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input int idx, input logic sec, output int v);
        @(negedge clk);
        cfg_sec = sec; cfg_idx = 3'(idx);
        #1 v = int'(cfg_rdata);
    endtask

    task automatic set_line(input int s, input logic v);
        @(negedge clk) irq_line[s] = v;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        chk("R7 reset id cpu0", id_of(0), SP);
        chk("R7 reset id cpu1", id_of(1), SP);
        chk("R7 reset irq", int'(cpu_irq), 0);

        // all sources: level, one-of-N, enabled, non-secure
        for (int s = 0; s < NS; s++) cfg_write(s, 4'b1000, 1'b0);

        // R3 table walk
        for (int i = 0; i < 6; i++) begin
            @(negedge clk) irq_line = VEC[i][17:10];
            ack(2'b01);
            chk($sformatf("R3 vector %0d", i), id_of(0), int'(VEC[i][9:0]));
            @(negedge clk) irq_line = '0;
            if (id_of(0) != SP) eoi(0, id_of(0));
        end

        // R1 edge capture on source 2
        cfg_write(2, 4'b1001, 1'b0);
        set_line(2, 1'b1);
        ack(2'b01);
        chk("R1 edge ack", id_of(0), 2);
        eoi(0, 2);
        @(negedge clk);
        chk("R1 no repend while high", int'(cpu_irq[0]), 0);
        ack(2'b01);
        chk("R1 held high spurious", id_of(0), SP);
        set_line(2, 1'b0);
        set_line(2, 1'b1);
        ack(2'b01);
        chk("R1 new edge ack", id_of(0), 2);
        eoi(0, 2);
        set_line(2, 1'b0);

        // R2 level withdrawal on source 4
        set_line(4, 1'b1);
        @(negedge clk);
        chk("R2 level pending", int'(cpu_irq[0]), 1);
        irq_line[4] = 1'b0;
        @(negedge clk);
        chk("R2 withdrawn irq", int'(cpu_irq[0]), 0);
        ack(2'b01);
        chk("R2 withdrawn ack", id_of(0), SP);

        // R8 / R9 active state and level re-pend
        set_line(4, 1'b1);
        ack(2'b01);
        chk("R8 first ack", id_of(0), 4);
        ack(2'b01);
        chk("R8 active not reissued", id_of(0), SP);
        eoi(0, 5);
        ack(2'b01);
        chk("R8 wrong eoi keeps active", id_of(0), SP);
        eoi(0, 4);
        ack(2'b01);
        chk("R9 level repends after eoi", id_of(0), 4);
        set_line(4, 1'b0);
        eoi(0, 4);

        // R4 one-of-N claim on source 3
        set_line(3, 1'b1);
        ack(2'b01);
        chk("R4 first claimer", id_of(0), 3);
        ack(2'b10);
        chk("R4 late acknowledger", id_of(1), SP);
        eoi(0, 3);
        ack(2'b10);
        chk("R4 reissue after eoi cpu1", id_of(1), 3);
        set_line(3, 1'b0);
        eoi(1, 3);

        // R5 simultaneous one-of-N on source 6
        set_line(6, 1'b1);
        ack(2'b11);
        chk("R5 cpu0 wins", id_of(0), 6);
        chk("R5 cpu1 spurious", id_of(1), SP);
        set_line(6, 1'b0);
        eoi(0, 6);

        // R6 all-N level source 5, simultaneous
        cfg_write(5, 4'b1010, 1'b0);
        set_line(5, 1'b1);
        ack(2'b11);
        chk("R6 all-N cpu0", id_of(0), 5);
        chk("R6 all-N cpu1", id_of(1), 5);
        set_line(5, 1'b0);
        eoi(0, 5);
        eoi(1, 5);

        // R6 all-N edge source 1, separate acks
        cfg_write(1, 4'b1011, 1'b0);
        set_line(1, 1'b1);
        set_line(1, 1'b0);
        ack(2'b10);
        chk("R6 edge cpu1", id_of(1), 1);
        chk("R6 still pending cpu0", int'(cpu_irq[0]), 1);
        ack(2'b01);
        chk("R6 edge cpu0", id_of(0), 1);
        eoi(0, 1);
        eoi(1, 1);

        // R11 disable while pending
        set_line(4, 1'b1);
        @(negedge clk);
        chk("R11 pending before disable", int'(cpu_irq[0]), 1);
        cfg_write(4, 4'b0000, 1'b0);
        chk("R11 no request when disabled", int'(cpu_irq[0]), 0);
        ack(2'b01);
        chk("R11 disabled ack spurious", id_of(0), SP);
        set_line(4, 1'b0);
        cfg_write(4, 4'b1000, 1'b0);

        // R10 security filter
        cfg_write(7, 4'b1100, 1'b1);
        cfg_read(7, 1'b0, v);
        chk("R10 nonsecure read of secure", v, 0);
        cfg_read(7, 1'b1, v);
        chk("R10 secure read", v, 12);
        cfg_write(7, 4'b0000, 1'b0);
        cfg_read(7, 1'b1, v);
        chk("R10 nonsecure write blocked", v, 12);
        cfg_write(0, 4'b1100, 1'b0);
        cfg_read(0, 1'b1, v);
        chk("R10 nonsecure cannot set secure", v, 8);
        cfg_read(0, 1'b0, v);
        chk("R10 nonsecure read allowed", v, 8);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule